// File: doc/BRIEF.md
# Configurable Routing Pin Cell

This block is one pin's cell in a signal-routing crosspoint fabric. Four routed data inputs reach a 4:1 dynamic multiplexer. Two select lines steer it, and each select line has its own programmable polarity. One storage element can be set up as an edge-triggered register or as a transparent latch, or it can be bypassed entirely.

The storage element can be placed in one of two paths. In the output path, the multiplexer feeds it and it drives the pin. In the input path, the pin feeds it and it drives the return signal into the routing pool. The cell also provides an output polarity control, a per-pin output enable with its own polarity, and a choice of clock between four global clocks and one routed clock. The clock polarity is programmable. An asynchronous global reset clears the storage element.

All configuration arrives on static input bits. Configuration is expected to change only while the global reset is high.

Top module: `xpc_pin_cell`

## Requirements
- R1: The effective select code {sel1,sel0} picks a data input as follows: 00 picks din[0], 01 picks din[1], 11 picks din[2] and 10 picks din[3].
- R2: Each select line is XORed with its own bit of cfg_sel_inv (bit 0 with sel_raw[0], bit 1 with sel_raw[1]) before decoding.
- R3: With cfg_bypass=1, pin_out follows the multiplexer combinationally and pool_out follows pin_in combinationally, whatever the path setting and the clocks.
- R4: In register mode (cfg_latch=0), the output path (cfg_path_in=0) and no bypass, the multiplexer value is captured on the rising edge of the effective clock and drives pin_out. The value holds at all other times.
- R5: In latch mode (cfg_latch=1), the element passes its input while the effective clock is high and holds it while that clock is low.
- R6: With cfg_path_in=1 and no bypass, the element stores pin_in and drives pool_out, while pin_out follows the multiplexer combinationally.
- R7: With cfg_path_in=0, pool_out equals pin_in.
- R8: The effective clock is gclk[n] when cfg_clk_src=n for n in 0..3. When cfg_clk_src is 4 or above, the effective clock is io_clk. The chosen clock is then XORed with cfg_clk_inv, so an inverted register captures on the falling edge of the source.
- R9: With cfg_out_inv=1, pin_out is the complement of the value that would otherwise drive it.
- R10: pin_oe equals oe_raw XOR cfg_oe_inv.
- R11: While gsr is high, the storage output is 0 immediately, with no clock edge needed. In the output path, pin_out then equals cfg_out_inv. In the input path, pool_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 4 | Dedicated global clocks |
| io_clk | input | 1 | Clock arriving through the routing pool |
| gsr | input | 1 | Asynchronous global reset, active high |
| din | input | 4 | Routed data inputs to the 4:1 multiplexer |
| sel_raw | input | 2 | Select lines before polarity adjustment |
| oe_raw | input | 1 | Output enable before polarity adjustment |
| pin_in | input | 1 | Value received at the pin |
| cfg_sel_inv | input | 2 | Per-line select inversion |
| cfg_clk_inv | input | 1 | Clock inversion |
| cfg_oe_inv | input | 1 | Output enable inversion |
| cfg_out_inv | input | 1 | Pin output inversion |
| cfg_path_in | input | 1 | 0: storage in output path, 1: storage in input path |
| cfg_bypass | input | 1 | 1: skip the storage element |
| cfg_latch | input | 1 | 0: edge register, 1: transparent latch |
| cfg_clk_src | input | 3 | 0..3 global clock index, 4 or above routed clock |
| pin_out | output | 1 | Value driven to the pin |
| pin_oe | output | 1 | Pin output enable |
| pool_out | output | 1 | Return signal into the routing pool |

## Verification
Every combinational result (select decoding, polarity, bypass, the output enable, and the pin-to-pool passthrough) is due in the same time step as its stimulus. The bench reads these results 1 ns after changing an input. Registered and latched results depend only on edges of the selected clock. The bench generates every such edge itself, away from the free-running clock, and samples 1 ns after each edge. Hold behaviour is checked after a data change and after a wrong-edge or wrong-clock pulse, and always before the next capturing edge. The effect of reset is read 1 ns after gsr rises, with no clock activity in between.

// File: rtl/xpc_pkg.sv
package xpc_pkg;

    localparam int NUM_DIN = 4;
    localparam int SEL_W   = 2;

    typedef enum logic [1:0] {
        SRC_A = 2'd0,
        SRC_B = 2'd1,
        SRC_C = 2'd2,
        SRC_D = 2'd3
    } src_e;

    typedef enum logic {
        PATH_OUT = 1'b0,
        PATH_IN  = 1'b1
    } path_e;

    typedef enum logic {
        STORE_REG   = 1'b0,
        STORE_LATCH = 1'b1
    } store_e;

    typedef struct packed {
        logic  bypass;
        path_e path;
        logic  out_inv;
    } route_cfg_t;

    // Select code ordering: 00 A, 01 B, 11 C, 10 D
    function automatic src_e decode_sel(input logic [SEL_W-1:0] code);
        src_e r;
        case (code)
            2'b00:   r = SRC_A;
            2'b01:   r = SRC_B;
            2'b11:   r = SRC_C;
            default: r = SRC_D;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xpc_sel_mux.sv
module xpc_sel_mux
    import xpc_pkg::*;
(
    input  logic [NUM_DIN-1:0] din,
    input  logic [SEL_W-1:0]   sel_raw,
    input  logic [SEL_W-1:0]   sel_inv,
    output logic               dout
);
    logic [SEL_W-1:0] sel_eff;
    src_e             src;

    assign sel_eff = sel_raw ^ sel_inv;
    assign src     = decode_sel(sel_eff);

    always_comb begin
        case (src)
            SRC_A:   dout = din[0];
            SRC_B:   dout = din[1];
            SRC_C:   dout = din[2];
            default: dout = din[3];
        endcase
    end
endmodule

// File: rtl/xpc_clk_pick.sv
module xpc_clk_pick #(
    parameter int NUM_GCLK  = 4,
    parameter int CLK_SRC_W = $clog2(NUM_GCLK) + 1
) (
    input  logic [NUM_GCLK-1:0]  gclk,
    input  logic                 io_clk,
    input  logic [CLK_SRC_W-1:0] src,
    input  logic                 inv,
    output logic                 clk_eff
);
    logic [NUM_GCLK-1:0] hit;
    logic                picked;

    for (genvar g = 0; g < NUM_GCLK; g++) begin : g_hit
        assign hit[g] = (src == CLK_SRC_W'(g));
    end

    assign picked  = (|(hit & gclk)) | ((~|hit) & io_clk);
    assign clk_eff = picked ^ inv;
endmodule

// File: rtl/xpc_store.sv
module xpc_store
    import xpc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  store_e mode,
    input  logic   d,
    output logic   q
);
    logic reg_q;
    logic lat_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) reg_q <= 1'b0;
        else     reg_q <= d;
    end

    always_latch begin
        if (rst)      lat_q = 1'b0;
        else if (clk) lat_q = d;
    end

    assign q = (mode == STORE_LATCH) ? lat_q : reg_q;
endmodule

// File: rtl/xpc_pin_cell.sv
module xpc_pin_cell
    import xpc_pkg::*;
#(
    parameter int NUM_GCLK  = 4,
    localparam int CLK_SRC_W = $clog2(NUM_GCLK) + 1
) (
    input  logic [NUM_GCLK-1:0]  gclk,
    input  logic                 io_clk,
    input  logic                 gsr,
    input  logic [NUM_DIN-1:0]   din,
    input  logic [SEL_W-1:0]     sel_raw,
    input  logic                 oe_raw,
    input  logic                 pin_in,
    input  logic [SEL_W-1:0]     cfg_sel_inv,
    input  logic                 cfg_clk_inv,
    input  logic                 cfg_oe_inv,
    input  logic                 cfg_out_inv,
    input  logic                 cfg_path_in,
    input  logic                 cfg_bypass,
    input  logic                 cfg_latch,
    input  logic [CLK_SRC_W-1:0] cfg_clk_src,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 pool_out
);
    route_cfg_t rcfg;
    logic       mux_o;
    logic       clk_eff;
    logic       store_d;
    logic       store_q;
    logic       core_out;

    assign rcfg.bypass  = cfg_bypass;
    assign rcfg.path    = path_e'(cfg_path_in);
    assign rcfg.out_inv = cfg_out_inv;

    xpc_sel_mux u_mux (
        .din     (din),
        .sel_raw (sel_raw),
        .sel_inv (cfg_sel_inv),
        .dout    (mux_o)
    );

    xpc_clk_pick #(.NUM_GCLK(NUM_GCLK), .CLK_SRC_W(CLK_SRC_W)) u_clk (
        .gclk    (gclk),
        .io_clk  (io_clk),
        .src     (cfg_clk_src),
        .inv     (cfg_clk_inv),
        .clk_eff (clk_eff)
    );

    assign store_d = (rcfg.path == PATH_IN) ? pin_in : mux_o;

    xpc_store u_store (
        .clk  (clk_eff),
        .rst  (gsr),
        .mode (store_e'(cfg_latch)),
        .d    (store_d),
        .q    (store_q)
    );

    always_comb begin
        if (rcfg.bypass || rcfg.path == PATH_IN) core_out = mux_o;
        else                                     core_out = store_q;
    end

    always_comb begin
        if (rcfg.bypass || rcfg.path == PATH_OUT) pool_out = pin_in;
        else                                      pool_out = store_q;
    end

    assign pin_out = core_out ^ rcfg.out_inv;
    assign pin_oe  = oe_raw ^ cfg_oe_inv;
endmodule

// File: rtl/xpc_pin_cell_chk.sv
module xpc_pin_cell_chk #(
    parameter int NUM_GCLK  = 4,
    parameter int CLK_SRC_W = $clog2(NUM_GCLK) + 1
) (
    input logic [NUM_GCLK-1:0]  gclk,
    input logic                 io_clk,
    input logic                 gsr,
    input logic [3:0]           din,
    input logic [1:0]           sel_raw,
    input logic                 oe_raw,
    input logic                 pin_in,
    input logic [1:0]           cfg_sel_inv,
    input logic                 cfg_clk_inv,
    input logic                 cfg_oe_inv,
    input logic                 cfg_out_inv,
    input logic                 cfg_path_in,
    input logic                 cfg_bypass,
    input logic                 cfg_latch,
    input logic [CLK_SRC_W-1:0] cfg_clk_src,
    input logic                 pin_out,
    input logic                 pin_oe,
    input logic                 pool_out
);
    logic       chk_clk;
    logic [1:0] s_eff;
    logic [1:0] exp_idx;
    logic       exp_mux;

    assign chk_clk = gclk[0];
    assign s_eff   = sel_raw ^ cfg_sel_inv;
    // Gray-style decode of the select code: 00->0, 01->1, 11->2, 10->3
    assign exp_idx = {s_eff[1], s_eff[1] ^ s_eff[0]};
    assign exp_mux = din[exp_idx];

    // R1 R3 R9: bypassed output follows the decoded data input
    a_r1_bypass_select: assert property (@(posedge chk_clk) disable iff (gsr)
        cfg_bypass |-> pin_out == (exp_mux ^ cfg_out_inv));

    // R6: input-path placement leaves the pin output combinational
    a_r6_inpath_pin: assert property (@(posedge chk_clk) disable iff (gsr)
        cfg_path_in |-> pin_out == (exp_mux ^ cfg_out_inv));

    // R7 R3: pool return is the raw pin in output path or bypass
    a_r7_pool_passthru: assert property (@(posedge chk_clk) disable iff (gsr)
        (!cfg_path_in || cfg_bypass) |-> pool_out == pin_in);

    // R10: output enable polarity
    a_r10_oe_polarity: assert property (@(posedge chk_clk) disable iff (gsr)
        pin_oe == (oe_raw ^ cfg_oe_inv));

    // R11: reset is the subject here, so it cannot also disable the check
    a_r11_reset_clears: assert property (@(posedge chk_clk)
        (gsr && !cfg_bypass) |->
            (cfg_path_in ? (pool_out == 1'b0) : (pin_out == cfg_out_inv)));

    logic unused_ok;
    assign unused_ok = ^{io_clk, cfg_clk_inv, cfg_latch, cfg_clk_src};
endmodule

bind xpc_pin_cell xpc_pin_cell_chk #(.NUM_GCLK(NUM_GCLK), .CLK_SRC_W(CLK_SRC_W)) chk_i (.*);

// File: tb/xpc_pin_cell_tb_top.sv
module xpc_pin_cell_tb_top;

    logic       clk = 1'b0;
    logic       gck1, gck2, gck3, io_clk, gsr;
    logic [3:0] gclk;
    logic [3:0] din;
    logic [1:0] sel_raw, cfg_sel_inv;
    logic       oe_raw, pin_in;
    logic       cfg_clk_inv, cfg_oe_inv, cfg_out_inv, cfg_path_in, cfg_bypass, cfg_latch;
    logic [2:0] cfg_clk_src;
    logic       pin_out, pin_oe, pool_out;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;
    assign gclk = {gck3, gck2, gck1, clk};

    xpc_pin_cell dut_i (
        .gclk(gclk), .io_clk(io_clk), .gsr(gsr), .din(din), .sel_raw(sel_raw),
        .oe_raw(oe_raw), .pin_in(pin_in), .cfg_sel_inv(cfg_sel_inv),
        .cfg_clk_inv(cfg_clk_inv), .cfg_oe_inv(cfg_oe_inv), .cfg_out_inv(cfg_out_inv),
        .cfg_path_in(cfg_path_in), .cfg_bypass(cfg_bypass), .cfg_latch(cfg_latch),
        .cfg_clk_src(cfg_clk_src), .pin_out(pin_out), .pin_oe(pin_oe), .pool_out(pool_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Enter configuration: reset high, clocks low, defaults applied
    task automatic begin_cfg();
        gsr = 1'b1;
        gck1 = 0; gck2 = 0; gck3 = 0; io_clk = 0;
        din = 4'b0000; sel_raw = 2'b00; cfg_sel_inv = 2'b00;
        oe_raw = 0; pin_in = 0;
        cfg_clk_inv = 0; cfg_oe_inv = 0; cfg_out_inv = 0;
        cfg_path_in = 0; cfg_bypass = 0; cfg_latch = 0; cfg_clk_src = 3'd2;
        #1;
    endtask

    task automatic end_cfg();
        #1 gsr = 1'b0;
        #1;
    endtask

    function automatic logic [1:0] code_for(input int idx);
        case (idx)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic t_reset_state();
        begin_cfg();
        check("R11 reset pin_out", pin_out, 1'b0);
        check("R7 reset pool passthru", pool_out, 1'b0);
        cfg_out_inv = 1; #1;
        check("R11 reset pin_out inverted", pin_out, 1'b1);
        end_cfg();
    endtask

    task automatic t_select_map();
        begin_cfg(); cfg_bypass = 1; end_cfg();
        for (int i = 0; i < 4; i++) begin
            sel_raw = code_for(i);
            din = 4'b0001 << i; #1;
            check("R1 selected input high", pin_out, 1'b1);
            din = ~(4'b0001 << i); #1;
            check("R1 selected input low", pin_out, 1'b0);
        end
    endtask

    task automatic t_sel_polarity();
        begin_cfg(); cfg_bypass = 1; end_cfg();
        sel_raw = 2'b00; din = 4'b0010; cfg_sel_inv = 2'b01; #1;
        check("R2 inv bit0 -> B", pin_out, 1'b1);
        din = 4'b1000; cfg_sel_inv = 2'b10; #1;
        check("R2 inv bit1 -> D", pin_out, 1'b1);
        din = 4'b0100; cfg_sel_inv = 2'b11; #1;
        check("R2 inv both -> C", pin_out, 1'b1);
        din = 4'b1011; #1;
        check("R2 inv both -> C low", pin_out, 1'b0);
    endtask

    task automatic t_polarity_oe();
        begin_cfg(); cfg_bypass = 1; end_cfg();
        din = 4'b0001; cfg_out_inv = 1; #1;
        check("R9 output inverted", pin_out, 1'b0);
        din = 4'b0000; #1;
        check("R9 output inverted low", pin_out, 1'b1);
        oe_raw = 1; #1;
        check("R10 oe plain", pin_oe, 1'b1);
        cfg_oe_inv = 1; #1;
        check("R10 oe inverted", pin_oe, 1'b0);
        oe_raw = 0; #1;
        check("R10 oe inverted low", pin_oe, 1'b1);
    endtask

    task automatic t_bypass();
        begin_cfg(); cfg_bypass = 1; cfg_path_in = 1; end_cfg();
        pin_in = 1; #1;
        check("R3 pool follows pin", pool_out, 1'b1);
        pin_in = 0; #1;
        check("R3 pool follows pin low", pool_out, 1'b0);
        cfg_path_in = 0; din = 4'b0001; #1;
        check("R3 pin follows mux no clock", pin_out, 1'b1);
    endtask

    task automatic t_register();
        begin_cfg(); cfg_clk_src = 3'd2; end_cfg();
        din = 4'b0001; #1;
        check("R4 no capture before edge", pin_out, 1'b0);
        gck2 = 1; #1;
        check("R4 capture on rise", pin_out, 1'b1);
        din = 4'b0000; #1;
        check("R4 hold while high", pin_out, 1'b1);
        gck2 = 0; #1;
        check("R4 no capture on fall", pin_out, 1'b1);
        gck2 = 1; #1;
        check("R4 capture zero", pin_out, 1'b0);
        cfg_out_inv = 1; #1;
        check("R9 registered output inverted", pin_out, 1'b1);
    endtask

    task automatic t_clk_inv();
        begin_cfg(); cfg_clk_src = 3'd2; cfg_clk_inv = 1; end_cfg();
        din = 4'b0001; #1;
        gck2 = 1; #1;
        check("R8 inverted: no capture on source rise", pin_out, 1'b0);
        gck2 = 0; #1;
        check("R8 inverted: capture on source fall", pin_out, 1'b1);
    endtask

    task automatic t_clk_src();
        begin_cfg(); cfg_clk_src = 3'd1; end_cfg();
        din = 4'b0001; #1;
        gck3 = 1; gck2 = 1; io_clk = 1; #1;
        gck3 = 0; gck2 = 0; io_clk = 0; #1;
        check("R8 other clocks ignored", pin_out, 1'b0);
        gck1 = 1; #1;
        check("R8 gclk1 captures", pin_out, 1'b1);
        begin_cfg(); cfg_clk_src = 3'd4; end_cfg();
        din = 4'b0001; #1;
        gck1 = 1; #1; gck1 = 0; #1;
        check("R8 routed: gclk1 ignored", pin_out, 1'b0);
        io_clk = 1; #1;
        check("R8 routed clock captures", pin_out, 1'b1);
    endtask

    task automatic t_latch();
        begin_cfg(); cfg_latch = 1; cfg_clk_src = 3'd4; end_cfg();
        din = 4'b0001; #1;
        check("R5 closed latch holds reset", pin_out, 1'b0);
        io_clk = 1; #1;
        check("R5 open latch passes", pin_out, 1'b1);
        din = 4'b0000; #1;
        check("R5 transparent follows low", pin_out, 1'b0);
        din = 4'b0001; #1;
        io_clk = 0; #1;
        din = 4'b0000; #1;
        check("R5 closed latch holds", pin_out, 1'b1);
    endtask

    task automatic t_input_path();
        begin_cfg(); cfg_path_in = 1; cfg_clk_src = 3'd3; end_cfg();
        sel_raw = 2'b11; din = 4'b0100; #1;
        check("R6 pin_out combinational", pin_out, 1'b1);
        pin_in = 1; #1;
        check("R6 pool holds before edge", pool_out, 1'b0);
        gck3 = 1; #1;
        check("R6 pool captures pin", pool_out, 1'b1);
        pin_in = 0; #1;
        check("R6 pool holds after pin change", pool_out, 1'b1);
        gsr = 1; #1;
        check("R11 async reset clears pool", pool_out, 1'b0);
        gsr = 0; #1;
    endtask

    task automatic t_out_path_pool();
        begin_cfg(); end_cfg();
        pin_in = 1; #1;
        check("R7 pool equals pin high", pool_out, 1'b1);
        pin_in = 0; #1;
        check("R7 pool equals pin low", pool_out, 1'b0);
    endtask

    task automatic t_async_reset();
        begin_cfg(); cfg_clk_src = 3'd2; end_cfg();
        din = 4'b0001; gck2 = 1; #1;
        check("R4 loaded before reset", pin_out, 1'b1);
        gsr = 1; #1;
        check("R11 async clear without edge", pin_out, 1'b0);
        gsr = 0; #1;
    endtask

    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_select_map();
        t_sel_polarity();
        t_polarity_oe();
        t_bypass();
        t_register();
        t_clk_inv();
        t_clk_src();
        t_latch();
        t_input_path();
        t_out_path_pool();
        t_async_reset();
        #10;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule